// File: doc/BRIEF.md
# Mixed Page Size Translation Lookaside Buffer

This block is a fully associative data translation buffer that holds a parameterised number of entries (64 by default). Each entry maps one virtual page to one physical page. The page size is chosen per entry: a small entry covers 4KB and a large entry covers 4MB. On a lookup, every live entry compares the virtual address at the width its own size needs. The block then returns the physical address together with a result code. The code reports a clean hit, a miss, a page fault, a privilege fault or a write-protection fault.

When a lookup misses, the block asks an external hardware page walker for the mapping and stalls new requests until the walker answers. It installs the returned entry into a free slot if one exists. Otherwise it uses the slot a first-in first-out pointer names. The entry it displaces is sent out on a writeback port, so that the page table receives the usage and modification status gathered while the entry was cached. The requester issues the access again once the block accepts requests again.

Top module: `mpt_tlb`

## Requirements
- R1: After reset, req_ready is 1 and rsp_valid, walk_req_valid and wb_valid are 0. No entry is live, so the first lookup reports a miss.
- R2: An accepted request (req_valid and req_ready high at a rising edge) produces exactly one response, with rsp_valid high in the next cycle only. A small entry hits when its stored page number equals vaddr[43:12]. The address returned is {ppn, vaddr[11:0]}, with rsp_code 0 (hit).
- R3: A large entry hits when vaddr[43:22] equals the top 22 bits of its page number, whatever vaddr[21:12] holds. The address returned is {ppn[27:10], vaddr[21:0]}. Accesses outside that 4MB region miss.
- R4: A lookup that matches no live entry returns rsp_code 1 (miss). In that same response cycle, walk_req_valid rises with walk_req_vpn = vaddr[43:12]. Both stay unchanged until walk_rsp_valid is seen, and req_ready is 0 throughout.
- R5: The cycle after walk_rsp_valid is seen, the walker's entry is installed, walk_req_valid falls and req_ready returns to 1. Walker flags are laid out as [0] page-table valid, [1] referenced, [2] writable, [3] supervisor.
- R6: A hit on an entry whose page-table valid flag is clear returns rsp_code 2 (page fault). This code takes precedence over every other fault.
- R7: A user-mode access (req_super = 0) that hits an entry whose supervisor flag is set returns rsp_code 3 (privilege fault). The same access in supervisor mode is allowed.
- R8: A store that hits an entry whose writable flag is clear returns rsp_code 4 (write-protection fault), while a load to it hits. A privilege fault takes precedence over a write-protection fault.
- R9: A refill goes to the lowest-numbered empty slot while one exists. Otherwise it goes to the slot named by a pointer that steps by one, modulo the entry count, on every refill. If the victim was live, wb_valid pulses in the cycle after walk_rsp_valid. It carries the victim's page numbers, size and flags, laid out as [0] page-table valid, [1] referenced, [2] writable, [3] supervisor, [4] used, [5] modified.
- R10: An access that returns rsp_code 0 sets the entry's used flag, and a store that returns rsp_code 0 also sets its modified flag. A faulting access changes neither flag. Both flags are installed clear.
- R11: A large entry is installed with the low 10 bits of its virtual and physical page numbers forced to zero.
- R12: rsp_paddr is zero whenever rsp_code is not 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Block can accept a lookup (low while a refill is outstanding) |
| req_vaddr | input | 44 | Virtual address |
| req_store | input | 1 | 1 for a store, 0 for a load |
| req_super | input | 1 | 1 when the access runs in supervisor mode |
| rsp_valid | output | 1 | Lookup result present |
| rsp_code | output | 3 | 0 hit, 1 miss, 2 page fault, 3 privilege fault, 4 write-protection fault |
| rsp_paddr | output | 40 | Physical address (zero unless the code is 0) |
| walk_req_valid | output | 1 | Refill request to the page walker |
| walk_req_vpn | output | 32 | Virtual page number to walk |
| walk_rsp_valid | input | 1 | Walker answer present |
| walk_rsp_ppn | input | 28 | Physical page number from the walker |
| walk_rsp_big | input | 1 | 1 when the mapping is a 4MB page |
| walk_rsp_flags | input | 4 | Page table flags from the walker |
| wb_valid | output | 1 | Evicted entry present |
| wb_vpn | output | 32 | Evicted virtual page number |
| wb_ppn | output | 28 | Evicted physical page number |
| wb_big | output | 1 | Evicted entry size |
| wb_flags | output | 6 | Evicted flags including used and modified |

## Verification
A lookup result is due in the cycle right after the request is accepted. The walker request appears in that same miss-response cycle, while req_ready and the writeback both change in the cycle after the walker answers. The scoreboard stamps every expected result with the cycle it is due in and compares that stamp when the result arrives. All outputs are sampled on the falling clock edge, midway between the edges where they change. Writeback items are predicted when the walker answer is driven and are matched in the cycle after it. The refill task checks the stall and the readiness timing at those same points.

// File: rtl/mpt_pkg.sv
package mpt_pkg;
  parameter int VA_W     = 44;
  parameter int PA_W     = 40;
  parameter int SMALL_SH = 12;
  parameter int BIG_SH   = 22;

  localparam int VPN_W  = VA_W - SMALL_SH;
  localparam int PPN_W  = PA_W - SMALL_SH;
  localparam int SPAN_W = BIG_SH - SMALL_SH;
  localparam int WFL_W  = 4;
  localparam int WBF_W  = 6;

  typedef enum logic [2:0] {
    RC_HIT   = 3'd0,
    RC_MISS  = 3'd1,
    RC_PAGE  = 3'd2,
    RC_PRIV  = 3'd3,
    RC_WPROT = 3'd4
  } rcode_e;

  typedef struct packed {
    logic             live;
    logic             big;
    logic [VPN_W-1:0] vpn;
    logic [PPN_W-1:0] ppn;
    logic             pte_ok;
    logic             refd;
    logic             wren;
    logic             supv;
    logic             used;
    logic             dirty;
  } tlb_ent_t;
endpackage

// File: rtl/mpt_pick.sv
module mpt_pick #(
  parameter int N = 64,
  localparam int W = $clog2(N)
) (
  input  logic [N-1:0] vec,
  output logic         any,
  output logic [W-1:0] idx
);
  // lowest set bit wins
  always_comb begin
    any = |vec;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = W'(i);
    end
  end
endmodule

// File: rtl/mpt_match.sv
module mpt_match
  import mpt_pkg::*;
#(
  parameter int ENTRIES = 64
) (
  input  tlb_ent_t [ENTRIES-1:0] ents,
  input  logic [VPN_W-1:0]       vpn,
  output logic [ENTRIES-1:0]     hit_vec
);
  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    logic hi_eq;
    logic lo_eq;
    assign hi_eq = ents[i].vpn[VPN_W-1:SPAN_W] == vpn[VPN_W-1:SPAN_W];
    assign lo_eq = ents[i].vpn[SPAN_W-1:0] == vpn[SPAN_W-1:0];
    assign hit_vec[i] = ents[i].live && hi_eq && (ents[i].big || lo_eq);
  end
endmodule

// File: rtl/mpt_victim.sv
module mpt_victim #(
  parameter int ENTRIES = 64,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ENTRIES-1:0] live_vec,
  input  logic               adv,
  output logic [IDX_W-1:0]   slot
);
  logic [IDX_W-1:0] ptr;
  logic             free_any;
  logic [IDX_W-1:0] free_idx;

  mpt_pick #(.N(ENTRIES)) u_free_pick (
    .vec(~live_vec),
    .any(free_any),
    .idx(free_idx)
  );

  assign slot = free_any ? free_idx : ptr;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr <= '0;
    end else if (adv) begin
      ptr <= (ptr == IDX_W'(ENTRIES - 1)) ? '0 : ptr + IDX_W'(1);
    end
  end

  // R9: pointer steps by one (with wrap) on each refill
  p_ptr_step_r9: assert property (@(posedge clk) disable iff (rst)
    adv |=> ptr == (($past(ptr) == IDX_W'(ENTRIES - 1)) ? '0 : $past(ptr) + IDX_W'(1)));

  // R9: pointer holds when no refill happens
  p_ptr_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(ptr));
endmodule

// File: rtl/mpt_tlb.sv
module mpt_tlb
  import mpt_pkg::*;
#(
  parameter int ENTRIES = 64,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic             req_store,
  input  logic             req_super,
  output logic             rsp_valid,
  output logic [2:0]       rsp_code,
  output logic [PA_W-1:0]  rsp_paddr,
  output logic             walk_req_valid,
  output logic [VPN_W-1:0] walk_req_vpn,
  input  logic             walk_rsp_valid,
  input  logic [PPN_W-1:0] walk_rsp_ppn,
  input  logic             walk_rsp_big,
  input  logic [WFL_W-1:0] walk_rsp_flags,
  output logic             wb_valid,
  output logic [VPN_W-1:0] wb_vpn,
  output logic [PPN_W-1:0] wb_ppn,
  output logic             wb_big,
  output logic [WBF_W-1:0] wb_flags
);
  tlb_ent_t [ENTRIES-1:0] tab;
  logic [ENTRIES-1:0]     hit_vec;
  logic [ENTRIES-1:0]     live_vec;
  logic                   hit_any;
  logic [IDX_W-1:0]       hit_idx;
  logic [IDX_W-1:0]       vic_slot;
  logic                   acc;
  logic                   fill_fire;
  rcode_e                 code_c;
  logic [PA_W-1:0]        pa_c;
  tlb_ent_t               new_ent;

  assign req_ready = !walk_req_valid;
  assign acc       = req_valid && req_ready;
  assign fill_fire = walk_req_valid && walk_rsp_valid;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_live
    assign live_vec[i] = tab[i].live;
  end

  mpt_match #(.ENTRIES(ENTRIES)) u_match (
    .ents(tab),
    .vpn(req_vaddr[VA_W-1:SMALL_SH]),
    .hit_vec(hit_vec)
  );

  mpt_pick #(.N(ENTRIES)) u_hit_pick (
    .vec(hit_vec),
    .any(hit_any),
    .idx(hit_idx)
  );

  mpt_victim #(.ENTRIES(ENTRIES)) u_victim (
    .clk(clk),
    .rst(rst),
    .live_vec(live_vec),
    .adv(fill_fire),
    .slot(vic_slot)
  );

  // permission checks in priority order
  always_comb begin
    if (!hit_any)                                   code_c = RC_MISS;
    else if (!tab[hit_idx].pte_ok)                  code_c = RC_PAGE;
    else if (tab[hit_idx].supv && !req_super)       code_c = RC_PRIV;
    else if (req_store && !tab[hit_idx].wren)       code_c = RC_WPROT;
    else                                            code_c = RC_HIT;
  end

  always_comb begin
    if (tab[hit_idx].big)
      pa_c = {tab[hit_idx].ppn[PPN_W-1:SPAN_W], req_vaddr[BIG_SH-1:0]};
    else
      pa_c = {tab[hit_idx].ppn, req_vaddr[SMALL_SH-1:0]};
  end

  always_comb begin
    new_ent        = '0;
    new_ent.live   = 1'b1;
    new_ent.big    = walk_rsp_big;
    new_ent.vpn    = walk_req_vpn;
    new_ent.ppn    = walk_rsp_ppn;
    if (walk_rsp_big) begin
      new_ent.vpn[SPAN_W-1:0] = '0;
      new_ent.ppn[SPAN_W-1:0] = '0;
    end
    {new_ent.supv, new_ent.wren, new_ent.refd, new_ent.pte_ok} = walk_rsp_flags;
  end

  // entry storage: refill install or status update
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < ENTRIES; i++) tab[i] <= '0;
    end else if (fill_fire) begin
      tab[vic_slot] <= new_ent;
    end else if (acc && code_c == RC_HIT) begin
      tab[hit_idx].used <= 1'b1;
      if (req_store) tab[hit_idx].dirty <= 1'b1;
    end
  end

  // lookup response
  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_code  <= '0;
      rsp_paddr <= '0;
    end else begin
      rsp_valid <= acc;
      if (acc) begin
        rsp_code  <= code_c;
        rsp_paddr <= (code_c == RC_HIT) ? pa_c : '0;
      end
    end
  end

  // walker request
  always_ff @(posedge clk) begin
    if (rst) begin
      walk_req_valid <= 1'b0;
      walk_req_vpn   <= '0;
    end else if (acc && !hit_any) begin
      walk_req_valid <= 1'b1;
      walk_req_vpn   <= req_vaddr[VA_W-1:SMALL_SH];
    end else if (fill_fire) begin
      walk_req_valid <= 1'b0;
    end
  end

  // writeback of the displaced entry
  always_ff @(posedge clk) begin
    if (rst) begin
      wb_valid <= 1'b0;
      wb_vpn   <= '0;
      wb_ppn   <= '0;
      wb_big   <= 1'b0;
      wb_flags <= '0;
    end else begin
      wb_valid <= fill_fire && tab[vic_slot].live;
      if (fill_fire) begin
        wb_vpn   <= tab[vic_slot].vpn;
        wb_ppn   <= tab[vic_slot].ppn;
        wb_big   <= tab[vic_slot].big;
        wb_flags <= {tab[vic_slot].dirty, tab[vic_slot].used, tab[vic_slot].supv,
                     tab[vic_slot].wren, tab[vic_slot].refd, tab[vic_slot].pte_ok};
      end
    end
  end

  // R2: one response per accepted request, one cycle later
  p_rsp_latency_r2: assert property (@(posedge clk) disable iff (rst)
    acc |=> rsp_valid);
  p_rsp_only_accept_r2: assert property (@(posedge clk) disable iff (rst)
    !acc |=> !rsp_valid);

  // R4: a miss response comes with a walk request
  p_miss_walks_r4: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_code == RC_MISS) |-> walk_req_valid);
  p_walk_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (walk_req_valid && !walk_rsp_valid) |=> (walk_req_valid && $stable(walk_req_vpn)));

  // R5: ready returns right after the walker answers
  p_ready_back_r5: assert property (@(posedge clk) disable iff (rst)
    fill_fire |=> req_ready);

  // R9: writeback only follows a refill
  p_wb_follows_r9: assert property (@(posedge clk) disable iff (rst)
    wb_valid |-> $past(fill_fire));

  // R12: faulting or missing results carry no address
  p_noaddr_r12: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_code != RC_HIT) |-> rsp_paddr == '0);
endmodule

// File: tb/mpt_tlb_bench.sv
module mpt_tlb_bench;
  import mpt_pkg::*;
  localparam int N = 64;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic             req_valid = 1'b0;
  logic             req_ready;
  logic [VA_W-1:0]  req_vaddr = '0;
  logic             req_store = 1'b0;
  logic             req_super = 1'b0;
  logic             rsp_valid;
  logic [2:0]       rsp_code;
  logic [PA_W-1:0]  rsp_paddr;
  logic             walk_req_valid;
  logic [VPN_W-1:0] walk_req_vpn;
  logic             walk_rsp_valid = 1'b0;
  logic [PPN_W-1:0] walk_rsp_ppn = '0;
  logic             walk_rsp_big = 1'b0;
  logic [WFL_W-1:0] walk_rsp_flags = '0;
  logic             wb_valid;
  logic [VPN_W-1:0] wb_vpn;
  logic [PPN_W-1:0] wb_ppn;
  logic             wb_big;
  logic [WBF_W-1:0] wb_flags;

  mpt_tlb #(.ENTRIES(N)) u_mpt_tlb (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .req_store(req_store), .req_super(req_super),
    .rsp_valid(rsp_valid), .rsp_code(rsp_code), .rsp_paddr(rsp_paddr),
    .walk_req_valid(walk_req_valid), .walk_req_vpn(walk_req_vpn),
    .walk_rsp_valid(walk_rsp_valid), .walk_rsp_ppn(walk_rsp_ppn),
    .walk_rsp_big(walk_rsp_big), .walk_rsp_flags(walk_rsp_flags),
    .wb_valid(wb_valid), .wb_vpn(wb_vpn), .wb_ppn(wb_ppn),
    .wb_big(wb_big), .wb_flags(wb_flags)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0;
  int errors = 0;

  typedef struct {
    int              code;
    logic [PA_W-1:0] pa;
    int              due;
    string           rq;
  } rexp_t;

  typedef struct {
    logic [VPN_W-1:0] vpn;
    logic [PPN_W-1:0] ppn;
    logic             big;
    logic [WBF_W-1:0] fl;
  } wexp_t;

  rexp_t rq_q[$];
  wexp_t wb_q[$];

  // expected contents, built from the requirements
  logic             m_live  [N];
  logic [VPN_W-1:0] m_vpn   [N];
  logic [PPN_W-1:0] m_ppn   [N];
  logic             m_big   [N];
  logic [3:0]       m_fl    [N];
  logic             m_used  [N];
  logic             m_dirty [N];
  int               m_fill = 0;

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  // bench page table: region F.. is 4MB, bits 26:24 pick flags
  function automatic void pt(input logic [VPN_W-1:0] v, output logic [PPN_W-1:0] p,
                             output logic bg, output logic [3:0] fl);
    bg = (v[31:28] == 4'hF);
    p  = v[27:0] + 28'h0123400;
    fl = {v[26], ~v[25], 1'b1, ~v[24]};
  endfunction

  function automatic int mfind(input logic [VPN_W-1:0] v);
    for (int i = 0; i < N; i++) begin
      if (m_live[i] && (m_big[i] ? (m_vpn[i][31:10] == v[31:10]) : (m_vpn[i] == v)))
        return i;
    end
    return -1;
  endfunction

  task automatic refill(input logic [VPN_W-1:0] v);
    logic [PPN_W-1:0] p;
    logic             bg;
    logic [3:0]       fl;
    int               s;
    wexp_t            w;
    chk(walk_req_valid == 1'b1, "R4", "walk request raised", walk_req_valid, 1);
    chk(walk_req_vpn == v, "R4", "walk vpn", walk_req_vpn, v);
    chk(req_ready == 1'b0, "R4", "stall while walking", req_ready, 0);
    pt(v, p, bg, fl);
    s = m_fill % N;
    m_fill++;
    if (m_live[s]) begin
      w.vpn = m_vpn[s];
      w.ppn = m_ppn[s];
      w.big = m_big[s];
      w.fl  = {m_dirty[s], m_used[s], m_fl[s]};
      wb_q.push_back(w);
    end
    m_live[s]  = 1'b1;
    m_big[s]   = bg;
    m_vpn[s]   = bg ? {v[31:10], 10'b0} : v;
    m_ppn[s]   = bg ? {p[27:10], 10'b0} : p;
    m_fl[s]    = fl;
    m_used[s]  = 1'b0;
    m_dirty[s] = 1'b0;
    repeat (2) @(negedge clk);
    chk(walk_req_valid && !req_ready && walk_req_vpn == v, "R4", "request held",
        walk_req_vpn, v);
    walk_rsp_valid = 1'b1;
    walk_rsp_ppn   = p;
    walk_rsp_big   = bg;
    walk_rsp_flags = fl;
    @(negedge clk);
    walk_rsp_valid = 1'b0;
    chk(req_ready == 1'b1, "R5", "ready after refill", req_ready, 1);
    chk(walk_req_valid == 1'b0, "R5", "walk request dropped", walk_req_valid, 0);
  endtask

  task automatic access(input logic [VA_W-1:0] va, input bit st, input bit sv,
                        input string rq);
    int               k;
    rexp_t            e;
    logic [VPN_W-1:0] v;
    v    = va[VA_W-1:SMALL_SH];
    k    = mfind(v);
    e.rq = rq;
    e.pa = '0;
    if (k < 0)                              e.code = 1;
    else if (!m_fl[k][0])                   e.code = 2;
    else if (m_fl[k][3] && !sv)             e.code = 3;
    else if (st && !m_fl[k][2])             e.code = 4;
    else begin
      e.code = 0;
      e.pa   = m_big[k] ? {m_ppn[k][27:10], va[21:0]} : {m_ppn[k], va[11:0]};
      m_used[k] = 1'b1;
      if (st) m_dirty[k] = 1'b1;
    end
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    req_vaddr = va;
    req_store = st;
    req_super = sv;
    e.due = cyc + 1;
    rq_q.push_back(e);
    @(negedge clk);
    req_valid = 1'b0;
    if (k < 0) refill(v);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (rsp_valid) begin
        if (rq_q.size() == 0) begin
          chk(0, "R2", "unexpected response", rsp_code, 0);
        end else begin
          rexp_t e;
          e = rq_q.pop_front();
          chk(cyc == e.due, "R2", "response cycle", cyc, e.due);
          chk(int'(rsp_code) == e.code, e.rq, "code", rsp_code, e.code);
          chk(rsp_paddr == e.pa, (e.code == 0) ? e.rq : "R12", "paddr", rsp_paddr, e.pa);
        end
      end
      if (wb_valid) begin
        if (wb_q.size() == 0) begin
          chk(0, "R9", "unexpected writeback", wb_vpn, 0);
        end else begin
          wexp_t w;
          w = wb_q.pop_front();
          chk(wb_vpn == w.vpn, "R9 R11", "wb vpn", wb_vpn, w.vpn);
          chk(wb_ppn == w.ppn, "R9 R11", "wb ppn", wb_ppn, w.ppn);
          chk(wb_big == w.big, "R9", "wb size", wb_big, w.big);
          chk(wb_flags == w.fl, "R9 R10", "wb flags", wb_flags, w.fl);
        end
      end
    end
  end

  function automatic logic [VA_W-1:0] mk(input logic [VPN_W-1:0] v, input logic [11:0] o);
    return {v, o};
  endfunction

  task automatic finish_run;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R1 watchdog: actual %0d cycles expected completion", cyc);
    finish_run();
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      m_live[i] = 1'b0; m_vpn[i] = '0; m_ppn[i] = '0; m_big[i] = 1'b0;
      m_fl[i] = '0; m_used[i] = 1'b0; m_dirty[i] = 1'b0;
    end
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1", "ready after reset", req_ready, 1);
    chk(rsp_valid == 1'b0, "R1", "no response after reset", rsp_valid, 0);
    chk(walk_req_valid == 1'b0, "R1", "no walk after reset", walk_req_valid, 0);
    chk(wb_valid == 1'b0, "R1", "no writeback after reset", wb_valid, 0);

    // R1 first access misses; R2 small page hit
    access(mk(32'h0000_0040, 12'h123), 1'b0, 1'b0, "R1");
    access(mk(32'h0000_0040, 12'hFFF), 1'b0, 1'b0, "R2");
    access(mk(32'h0000_0041, 12'h000), 1'b0, 1'b0, "R2");
    access(mk(32'h0000_0041, 12'h7A5), 1'b0, 1'b1, "R2");

    // R3 large pages
    access(mk(32'hF000_0C35, 12'h010), 1'b0, 1'b0, "R3");
    access(mk(32'hF000_0FFF, 12'hABC), 1'b0, 1'b0, "R3");
    access(mk(32'hF000_0C00, 12'h000), 1'b0, 1'b0, "R3");
    access(mk(32'hF000_1035, 12'h010), 1'b0, 1'b0, "R3");

    // R6 page fault and its precedence
    access(mk(32'h0100_0007, 12'h004), 1'b0, 1'b0, "R6");
    access(mk(32'h0100_0007, 12'h004), 1'b0, 1'b0, "R6");
    access(mk(32'h0100_0007, 12'h008), 1'b1, 1'b0, "R6");

    // R7 supervisor pages
    access(mk(32'h0400_0008, 12'h000), 1'b0, 1'b0, "R7");
    access(mk(32'h0400_0008, 12'h020), 1'b0, 1'b0, "R7");
    access(mk(32'h0400_0008, 12'h020), 1'b0, 1'b1, "R7");
    access(mk(32'h0400_0008, 12'h024), 1'b1, 1'b1, "R7");

    // R8 write protection and priority below privilege
    access(mk(32'h0200_0009, 12'h000), 1'b0, 1'b0, "R8");
    access(mk(32'h0200_0009, 12'h100), 1'b1, 1'b0, "R8");
    access(mk(32'h0200_0009, 12'h100), 1'b0, 1'b0, "R8");
    access(mk(32'h0600_000A, 12'h000), 1'b0, 1'b1, "R8");
    access(mk(32'h0600_000A, 12'h040), 1'b1, 1'b0, "R8");
    access(mk(32'h0600_000A, 12'h040), 1'b1, 1'b1, "R8");

    // R10 store hit marks modified
    access(mk(32'h0000_0040, 12'h200), 1'b1, 1'b0, "R10");

    // R9 fill every slot, then evict in FIFO order
    for (int i = 0; i < N; i++) begin
      access(mk(32'h0000_2000 + i, 12'h000), 1'b0, 1'b0, "R9");
    end
    access(mk(32'h0000_0040, 12'h123), 1'b0, 1'b0, "R9");
    access(mk(32'h0000_0040, 12'h321), 1'b0, 1'b0, "R9");

    repeat (4) @(negedge clk);
    chk(rq_q.size() == 0, "R2", "responses outstanding", rq_q.size(), 0);
    chk(wb_q.size() == 0, "R9", "writebacks outstanding", wb_q.size(), 0);
    finish_run();
  end
endmodule